// File: doc/BRIEF.md
# Crossbar Slave-Port Configuration Register Bank

This block holds the arbitration settings for the slave ports of a bus crossbar. Every active slave port owns two 32-bit registers. The first is a priority word with one 4-bit field per master. The second is a control word that selects the arbitration mode and the parking behaviour, and that carries a sticky lock bit. The register contents drive the arbiter directly through dedicated output buses. The arbiter reads the priority fields in fixed-priority mode. In round-robin mode it reads them only to separate masters that have both been raised to high priority.

Software reaches the bank through a single-cycle register bus. Each access carries a privilege flag and a size code. Only privileged full-word accesses to mapped offsets succeed. Every other access is refused with an error in the same cycle and changes nothing. When software writes 1 to a port's lock bit, both registers of that port are frozen until the next reset. Later writes to that port are refused with an error, while reads of it still succeed.

Top module: `xbar_port_cfg`

## Requirements
- R1: After reset, every priority register reads 0x5400_3210 and every control register reads 0x0000_0000.
- R2: Port n's priority register sits at byte address n*0x100 and its control register at n*0x100+0x10 (address bits [11:8] select n, bits [7:0] the register). The mapped ports are 2, 3, 6 and 7.
- R3: An access with req_priv_i low gets rsp_err_o high, reads zero and changes no register.
- R4: An access whose req_size_i is not 2 (full word; 0 = byte, 1 = half) gets rsp_err_o high, reads zero and changes no register.
- R5: An access to an address that does not match R2 gets rsp_err_o high and reads zero.
- R6: Priority field k sits in bits [4k+3:4k] and belongs to master k. The fields of masters 4 and 5 (bits [23:16]) always read zero, and writes to them are dropped.
- R7: Control layout: park master bits [2:0], park mode bits [5:4], round-robin enable bit 8, lock bit 31. All other bits read zero.
- R8: Once a port's lock bit is 1, any write to either of that port's registers gets an error and leaves both unchanged. Ports that are not locked are unaffected.
- R9: Reads of a locked port complete without error and return the stored values.
- R10: Writing 0 to a set lock bit neither clears it nor succeeds. Only reset clears it.
- R11: req_ready_o is always high. rsp_err_o and rsp_rdata_o are valid in the cycle of the request, and an accepted write is visible from the next cycle on.
- R12: prio_o, park_sel_o, park_mode_o, arb_rr_o and lock_o always equal the stored fields of the corresponding port. Slot i is mapped port i in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte address |
| req_size_i | input | 2 | Access size code, 2 = word |
| req_priv_i | input | 1 | Privileged access |
| req_wdata_i | input | 32 | Write data |
| req_ready_o | output | 1 | Request accepted (constant 1) |
| rsp_rdata_o | output | 32 | Read data, same cycle |
| rsp_err_o | output | 1 | Error response, same cycle |
| prio_o | output | 128 | Priority words, 32 bits per slot |
| park_sel_o | output | 12 | Park master, 3 bits per slot |
| park_mode_o | output | 8 | Park mode, 2 bits per slot |
| arb_rr_o | output | 4 | Round-robin enable per slot |
| lock_o | output | 4 | Lock state per slot |

## Verification
The hardest state to reach is a port that is locked and then receives writes that would otherwise change it. That includes writes of 0 to the lock bit, writes to the sibling priority register, and the release that only reset provides. The random stream sets the lock bit only rarely, so ports lock at scattered points and many refused writes follow. Directed steps lock one port, hammer it while a neighbour stays writable, and then apply reset in the middle of the run to show that the lock clears.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [1:0] SIZE_WORD = 2'd2;
  localparam logic [7:0] OFS_PRIO = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h10;

  typedef struct packed {
    logic       lock;
    logic       arb_rr;
    logic [1:0] park_mode;
    logic [2:0] park_sel;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c);
    return {c.lock, 22'd0, c.arb_rr, 2'd0, c.park_mode, 1'b0, c.park_sel};
  endfunction

  function automatic ctrl_t ctrl_unpack(logic [DATA_W-1:0] w);
    ctrl_t c;
    c.lock      = w[31];
    c.arb_rr    = w[8];
    c.park_mode = w[5:4];
    c.park_sel  = w[2:0];
    return c;
  endfunction
endpackage

// File: rtl/xbar_cfg_decode.sv
module xbar_cfg_decode
  import xbar_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NUM_ACT = 4,
  localparam int unsigned ID_W   = ADDR_W - 8,
  parameter logic [NUM_ACT*ID_W-1:0] PORT_IDS = {4'd7, 4'd6, 4'd3, 4'd2}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               write_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [1:0]         size_i,
  input  logic               priv_i,
  input  logic [NUM_ACT-1:0] lock_i,
  output logic [NUM_ACT-1:0] hit_o,
  output logic               sel_ctrl_o,
  output logic               err_o,
  output logic [NUM_ACT-1:0] wr_prio_o,
  output logic [NUM_ACT-1:0] wr_ctrl_o
);
  logic ofs_ok, access_ok, locked_hit, wr_ok;

  assign sel_ctrl_o = (addr_i[7:0] == OFS_CTRL);
  assign ofs_ok     = (addr_i[7:0] == OFS_PRIO) || sel_ctrl_o;

  for (genvar i = 0; i < NUM_ACT; i++) begin : g_hit
    assign hit_o[i]     = ofs_ok && (addr_i[ADDR_W-1:8] == PORT_IDS[i*ID_W +: ID_W]);
    assign wr_prio_o[i] = wr_ok && hit_o[i] && !sel_ctrl_o;
    assign wr_ctrl_o[i] = wr_ok && hit_o[i] && sel_ctrl_o;
  end

  assign locked_hit = |(hit_o & lock_i);
  assign access_ok  = valid_i && priv_i && (size_i == SIZE_WORD) && (|hit_o);
  assign wr_ok      = access_ok && write_i && !locked_hit;
  assign err_o      = valid_i && !(access_ok && !(write_i && locked_hit));

  assert_user_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !priv_i) |-> (err_o && (wr_prio_o == '0) && (wr_ctrl_o == '0)));
  assert_size_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i != SIZE_WORD) |-> (err_o && (wr_prio_o == '0) && (wr_ctrl_o == '0)));
  assert_one_target_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o) && $onehot0(wr_prio_o | wr_ctrl_o));
  assert_locked_wr_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && write_i && |(hit_o & lock_i)) |-> err_o);
endmodule

// File: rtl/xbar_cfg_port.sv
module xbar_cfg_port
  import xbar_cfg_pkg::*;
#(
  parameter int unsigned NUM_MST  = 8,
  parameter logic [NUM_MST-1:0] MST_MASK = 8'hCF,
  parameter logic [DATA_W-1:0]  PRIO_RST = 32'h5400_3210
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_prio_i,
  input  logic              wr_ctrl_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] prio_o,
  output ctrl_t             ctrl_o
);
  localparam int unsigned FIELD_W = DATA_W / NUM_MST;

  logic [DATA_W-1:0] prio_mask;
  for (genvar k = 0; k < NUM_MST; k++) begin : g_mask
    assign prio_mask[k*FIELD_W +: FIELD_W] = {FIELD_W{MST_MASK[k]}};
  end

  logic [DATA_W-1:0] prio_q;
  ctrl_t ctrl_q, ctrl_wr;

  assign ctrl_wr = ctrl_unpack(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= PRIO_RST & prio_mask;
      ctrl_q <= '0;
    end else begin
      if (wr_prio_i) prio_q <= wdata_i & prio_mask;
      if (wr_ctrl_i) begin
        ctrl_q.park_sel  <= ctrl_wr.park_sel;
        ctrl_q.park_mode <= ctrl_wr.park_mode;
        ctrl_q.arb_rr    <= ctrl_wr.arb_rr;
        ctrl_q.lock      <= ctrl_q.lock | ctrl_wr.lock; // sticky until reset
      end
    end
  end

  assign prio_o = prio_q;
  assign ctrl_o = ctrl_q;

  assert_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.lock |=> ($stable(prio_q) && $stable(ctrl_q)));
  assert_lock_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.lock |=> ctrl_q.lock);
  assert_no_locked_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.lock |-> !(wr_prio_i || wr_ctrl_i));
endmodule

// File: rtl/xbar_port_cfg.sv
module xbar_port_cfg
  import xbar_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NUM_ACT = 4,
  parameter int unsigned NUM_MST = 8,
  localparam int unsigned ID_W   = ADDR_W - 8,
  parameter logic [NUM_ACT*ID_W-1:0] PORT_IDS = {4'd7, 4'd6, 4'd3, 4'd2},
  parameter logic [NUM_MST-1:0] MST_MASK = 8'hCF,
  parameter logic [31:0] PRIO_RST = 32'h5400_3210
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [1:0]            req_size_i,
  input  logic                  req_priv_i,
  input  logic [31:0]           req_wdata_i,
  output logic                  req_ready_o,
  output logic [31:0]           rsp_rdata_o,
  output logic                  rsp_err_o,
  output logic [NUM_ACT*32-1:0] prio_o,
  output logic [NUM_ACT*3-1:0]  park_sel_o,
  output logic [NUM_ACT*2-1:0]  park_mode_o,
  output logic [NUM_ACT-1:0]    arb_rr_o,
  output logic [NUM_ACT-1:0]    lock_o
);
  logic [NUM_ACT-1:0] hit, wr_prio, wr_ctrl, lock;
  logic               sel_ctrl, err;
  logic [DATA_W-1:0]  prio_w [NUM_ACT];
  ctrl_t              ctrl_w [NUM_ACT];

  xbar_cfg_decode #(
    .ADDR_W(ADDR_W), .NUM_ACT(NUM_ACT), .PORT_IDS(PORT_IDS)
  ) u_decode (
    .clk_i, .rst_ni,
    .valid_i(req_valid_i), .write_i(req_write_i), .addr_i(req_addr_i),
    .size_i(req_size_i), .priv_i(req_priv_i), .lock_i(lock),
    .hit_o(hit), .sel_ctrl_o(sel_ctrl), .err_o(err),
    .wr_prio_o(wr_prio), .wr_ctrl_o(wr_ctrl)
  );

  for (genvar i = 0; i < NUM_ACT; i++) begin : g_port
    xbar_cfg_port #(
      .NUM_MST(NUM_MST), .MST_MASK(MST_MASK), .PRIO_RST(PRIO_RST)
    ) u_port (
      .clk_i, .rst_ni,
      .wr_prio_i(wr_prio[i]), .wr_ctrl_i(wr_ctrl[i]), .wdata_i(req_wdata_i),
      .prio_o(prio_w[i]), .ctrl_o(ctrl_w[i])
    );
    assign lock[i]               = ctrl_w[i].lock;
    assign prio_o[i*32 +: 32]    = prio_w[i];
    assign park_sel_o[i*3 +: 3]  = ctrl_w[i].park_sel;
    assign park_mode_o[i*2 +: 2] = ctrl_w[i].park_mode;
    assign arb_rr_o[i]           = ctrl_w[i].arb_rr;
  end

  assign lock_o = lock;

  always_comb begin
    rsp_rdata_o = '0;
    if (!err) begin
      for (int i = 0; i < NUM_ACT; i++) begin
        if (hit[i]) rsp_rdata_o = sel_ctrl ? ctrl_pack(ctrl_w[i]) : prio_w[i];
      end
    end
  end

  assign rsp_err_o   = err;
  assign req_ready_o = 1'b1;

  assert_err_no_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_rdata_o == '0));
  assert_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni) req_ready_o);
endmodule

// File: tb/xbar_port_cfg_tb.sv
module xbar_port_cfg_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0, req_priv_i = 1'b0;
  logic [11:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        req_ready_o, rsp_err_o;
  logic [31:0] rsp_rdata_o;
  logic [127:0] prio_o;
  logic [11:0] park_sel_o;
  logic [7:0]  park_mode_o;
  logic [3:0]  arb_rr_o, lock_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_prio [4];
  logic [31:0] m_ctrl [4];
  logic [3:0]  ids [4] = '{4'd2, 4'd3, 4'd6, 4'd7};

  xbar_port_cfg u_dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_prio[i] = 32'h5400_3210;
      m_ctrl[i] = 32'h0;
    end
  endtask

  function automatic int pidx(logic [11:0] a);
    if (a[7:0] != 8'h00 && a[7:0] != 8'h10) return -1;
    for (int i = 0; i < 4; i++) if (a[11:8] == ids[i]) return i;
    return -1;
  endfunction

  function automatic bit exp_err(bit w, logic [11:0] a, logic [1:0] sz, bit pv);
    int p = pidx(a);
    if (!pv || sz != 2'd2 || p < 0) return 1;
    return w && m_ctrl[p][31];
  endfunction

  function automatic logic [31:0] exp_rd(bit w, logic [11:0] a, logic [1:0] sz, bit pv);
    int p = pidx(a);
    if (exp_err(w, a, sz, pv)) return 32'h0;
    return (a[7:0] == 8'h10) ? m_ctrl[p] : m_prio[p];
  endfunction

  // one access: drive at negedge, check response before the edge, update model after it
  task automatic acc(input bit w, input logic [11:0] a, input logic [1:0] sz, input bit pv,
                     input logic [31:0] d, input string tag);
    bit e;
    logic [31:0] r;
    int p;
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = w; req_addr_i = a; req_size_i = sz;
    req_priv_i = pv; req_wdata_i = d;
    e = exp_err(w, a, sz, pv);
    r = exp_rd(w, a, sz, pv);
    #2;
    chk({31'd0, rsp_err_o}, {31'd0, e}, {tag, " err"});
    chk(rsp_rdata_o, r, {tag, " rdata"});
    chk({31'd0, req_ready_o}, 32'd1, "R11 ready");
    @(posedge clk_i);
    p = pidx(a);
    if (w && !e) begin
      if (a[7:0] == 8'h00) m_prio[p] = d & 32'hFF00_FFFF;
      else m_ctrl[p] = (d & 32'h0000_0137) | {m_ctrl[p][31] | d[31], 31'd0};
    end
    #1 req_valid_i = 0;
  endtask

  task automatic chk_outs(input string tag);
    @(negedge clk_i);
    for (int i = 0; i < 4; i++) begin
      chk(prio_o[i*32 +: 32], m_prio[i], {tag, " prio_o"});
      chk({29'd0, park_sel_o[i*3 +: 3]}, {29'd0, m_ctrl[i][2:0]}, {tag, " park_sel_o"});
      chk({30'd0, park_mode_o[i*2 +: 2]}, {30'd0, m_ctrl[i][5:4]}, {tag, " park_mode_o"});
      chk({31'd0, arb_rr_o[i]}, {31'd0, m_ctrl[i][8]}, {tag, " arb_rr_o"});
      chk({31'd0, lock_o[i]}, {31'd0, m_ctrl[i][31]}, {tag, " lock_o"});
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    model_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] a;
    logic [31:0] d;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset values, R2 map
    for (int i = 0; i < 4; i++) begin
      acc(0, {ids[i], 8'h00}, 2, 1, 0, "R1 R2 prio reset");
      acc(0, {ids[i], 8'h10}, 2, 1, 0, "R1 R2 ctrl reset");
    end
    chk_outs("R1 R12");
    // R3 user mode, R4 size, R5 unmapped
    acc(1, 12'h200, 2, 0, 32'h1111_1111, "R3 user write");
    acc(0, 12'h210, 2, 0, 0, "R3 user read");
    acc(1, 12'h300, 0, 1, 32'h2222_2222, "R4 byte write");
    acc(1, 12'h310, 1, 1, 32'h0000_0007, "R4 half write");
    acc(0, 12'h000, 2, 1, 0, "R5 port0");
    acc(1, 12'h204, 2, 1, 32'hFFFF_FFFF, "R5 reserved ofs");
    acc(0, 12'h400, 2, 1, 0, "R5 port4");
    acc(0, 12'h200, 2, 1, 0, "R3 R4 R5 no change");
    // R6 priority fields, R7 control layout, R11 visible next cycle
    acc(1, 12'h600, 2, 1, 32'hFFFF_FFFF, "R6 prio write");
    acc(0, 12'h600, 2, 1, 0, "R6 R11 prio readback");
    acc(1, 12'h610, 2, 1, 32'h7FFF_FFFF, "R7 ctrl write");
    acc(0, 12'h610, 2, 1, 0, "R7 R11 ctrl readback");
    chk_outs("R12 after writes");
    // R8 R9 R10 lock port 3
    acc(1, 12'h310, 2, 1, 32'h8000_0125, "R8 set lock");
    acc(1, 12'h300, 2, 1, 32'h0123_4567, "R8 locked prio write");
    acc(1, 12'h310, 2, 1, 32'h0000_0000, "R10 write 0 to lock");
    acc(0, 12'h300, 2, 1, 0, "R9 locked prio read");
    acc(0, 12'h310, 2, 1, 0, "R9 R10 locked ctrl read");
    acc(1, 12'h700, 2, 1, 32'h0765_4321, "R8 neighbour writable");
    acc(0, 12'h700, 2, 1, 0, "R8 neighbour readback");
    chk_outs("R12 R10 locked");
    do_reset();
    acc(0, 12'h310, 2, 1, 0, "R10 reset clears lock");
    acc(1, 12'h300, 2, 1, 32'h0000_1234, "R10 write after reset");
    acc(0, 12'h300, 2, 1, 0, "R10 readback after reset");
    chk_outs("R1 R12 after reset");

    // random phase
    for (int n = 0; n < 600; n++) begin
      int sel = $urandom % 8;
      if (sel < 6) a = {ids[$urandom % 4], (($urandom % 2) != 0) ? 8'h10 : 8'h00};
      else if (sel == 6) a = 12'($urandom);
      else a = {ids[$urandom % 4], 8'($urandom % 3 * 4 + 8'h10 * ($urandom % 2))};
      d = $urandom;
      if (($urandom % 40) != 0) d[31] = 1'b0;
      acc(($urandom % 2) != 0, a, (($urandom % 8) == 0) ? 2'($urandom % 4) : 2'd2,
          ($urandom % 8) != 0, d, "R2 R3 R4 R5 R6 R7 R8 R9 random");
      if (n % 50 == 49) chk_outs("R12 random");
      if (n == 300) do_reset();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule